// File: doc/BRIEF.md
# Single-Channel DMA Mover with Per-Side Width Adaptation

The block is one DMA channel. A start pulse latches a source base address, a destination base address, an item count, a width for each side (byte, half-word or word) and an increment option for each side. The channel then moves the items one at a time over a simple single-beat bus master port. Each item is one read from the source side followed by one write to the destination side. When the two widths differ, the item is narrowed to its least significant bytes or padded with zeros. One item read always gives exactly one item written. The channel never packs or splits items.

Three events are tracked: half of the items moved, all items moved, and a bus error. Each event has a sticky flag, a write-one-to-clear input and an interrupt enable. A single interrupt line combines the three. An error response ends the run at once. The channel then stays quiet until the next start pulse.

Top module: `xwdma_chan`

## Requirements
- R1: The width codes for each side are 0 = byte, 1 = half-word, 2 = word, and code 3 acts as word. The source and destination widths are set independently. `bus_size_o` shows the source width during a read and the destination width during a write.
- R2: When the destination is wider than the source, the written value is the source item held in the low bytes, with every higher bit zero.
- R3: When the destination is narrower than the source, the written value is the least significant destination-width bytes of the item read.
- R4: Each item is one read at the source address followed by one write at the destination address, and items go in order. A request holds its address and direction until `bus_ack_i` or `bus_err_i` is seen at a clock edge.
- R5: After each completed access, that side's address advances by 1, 2 or 4 bytes (its width) if its increment input was set at start. Otherwise the address stays at the base.
- R6: The remaining count drops by one after each completed write, and the channel goes idle after the last item. A start pulse with a count of zero issues no access.
- R7: Event bit 1 (complete) is set when the last write of the run completes.
- R8: Event bit 0 (half) is set when a completed write leaves exactly floor(N/2) items remaining, where N is the programmed count.
- R9: An error response on a read or a write sets event bit 2 (error) and ends the run. No further request is issued until the next start pulse.
- R10: A flag stays set until a 1 is written to its bit of `ev_clr_i`. If the flag is set and cleared in the same cycle, the set wins.
- R11: `irq_o` is high exactly when some flag is set and its bit of `ev_ie_i` is 1.
- R12: A start pulse while the channel is busy is ignored. The run in progress keeps its addresses, widths and count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that latches the setup and begins a run |
| src_base_i | input | AW | Source start address |
| dst_base_i | input | AW | Destination start address |
| items_i | input | CW | Number of items to move |
| src_sz_i | input | 2 | Source width code |
| dst_sz_i | input | 2 | Destination width code |
| src_inc_i | input | 1 | Source address advances per item |
| dst_inc_i | input | 1 | Destination address advances per item |
| ev_clr_i | input | 3 | Write-one-to-clear per event (0 half, 1 complete, 2 error) |
| ev_ie_i | input | 3 | Interrupt enable per event |
| bus_req_o | output | 1 | Access request |
| bus_we_o | output | 1 | 1 for write, 0 for read |
| bus_addr_o | output | AW | Access byte address |
| bus_size_o | output | 2 | Access width code |
| bus_wdata_o | output | 32 | Write data, right-aligned |
| bus_rdata_i | input | 32 | Read data, right-aligned |
| bus_ack_i | input | 1 | Access done this cycle |
| bus_err_i | input | 1 | Access failed this cycle |
| busy_o | output | 1 | A run is in progress |
| ev_flag_o | output | 3 | Sticky event flags |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check several rules on every cycle. A read that completes is always followed by a write. A pending request keeps its address and direction. An error is always followed by an idle bus. A byte-wide write never carries bits above the low byte. A set flag persists until cleared, and a set wins over a same-cycle clear. An address holds when it is neither loaded nor advanced. The scenarios are needed for the rest: the exact data values after widening and narrowing, the address sequences with and without increment, the point at which the half flag appears for odd and even counts, the interrupt gating, and the fact that a start pulse during a run is ignored.

// File: rtl/xwdma_pkg.sv
package xwdma_pkg;
   localparam int DATA_W = 32;
   localparam int NUM_EV = 3;
   localparam int EV_HALF = 0;
   localparam int EV_DONE = 1;
   localparam int EV_ERR  = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } phase_t;

   function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
      case (sz)
         2'd0:    lane_mask = DATA_W'(32'h0000_00FF);
         2'd1:    lane_mask = DATA_W'(32'h0000_FFFF);
         default: lane_mask = '1;
      endcase
   endfunction
endpackage

// File: rtl/xwdma_ptr.sv
module xwdma_ptr #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   input  logic          inc,
   input  logic [1:0]    sz,
   output logic [AW-1:0] addr
);
   logic [AW-1:0] step;

   always_comb begin
      case (sz)
         2'd0:    step = AW'(1);
         2'd1:    step = AW'(2);
         default: step = AW'(4);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr <= '0;
      else if (load)       addr <= base;
      else if (adv && inc) addr <= addr + step;
   end

   // R5
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !adv) |=> $stable(addr));
endmodule

// File: rtl/xwdma_fit.sv
module xwdma_fit
   import xwdma_pkg::*;
#(
   parameter bit ZERO_PAD = 1'b1
) (
   input  logic [DATA_W-1:0] din,
   input  logic [1:0]        src_sz,
   input  logic [1:0]        dst_sz,
   output logic [DATA_W-1:0] dout
);
   generate
      if (ZERO_PAD) begin : g_pad
         assign dout = din & lane_mask(src_sz) & lane_mask(dst_sz);
      end else begin : g_raw
         logic unused_sz;
         assign unused_sz = ^src_sz;
         assign dout = din & lane_mask(dst_sz);
      end
   endgenerate
endmodule

// File: rtl/xwdma_evt.sv
module xwdma_evt #(
   parameter int NEV = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] set,
   input  logic [NEV-1:0] clr,
   input  logic [NEV-1:0] ie,
   output logic [NEV-1:0] flag,
   output logic           irq
);
   generate
      if (NEV < 1) begin : g_bad_nev
         $error("xwdma_evt: NEV must be at least 1");
      end
      for (genvar g = 0; g < NEV; g++) begin : g_ev
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      flag[g] <= 1'b0;
            else if (set[g]) flag[g] <= 1'b1;
            else if (clr[g]) flag[g] <= 1'b0;
         end

         // R10
         flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag[g] && !clr[g]) |=> flag[g]);
         // R10
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[g] |=> flag[g]);
      end
   endgenerate

   assign irq = |(flag & ie);
endmodule

// File: rtl/xwdma_chan.sv
module xwdma_chan
   import xwdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [AW-1:0]     src_base_i,
   input  logic [AW-1:0]     dst_base_i,
   input  logic [CW-1:0]     items_i,
   input  logic [1:0]        src_sz_i,
   input  logic [1:0]        dst_sz_i,
   input  logic              src_inc_i,
   input  logic              dst_inc_i,
   input  logic [2:0]        ev_clr_i,
   input  logic [2:0]        ev_ie_i,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [AW-1:0]     bus_addr_o,
   output logic [1:0]        bus_size_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_ack_i,
   input  logic              bus_err_i,
   output logic              busy_o,
   output logic [2:0]        ev_flag_o,
   output logic              irq_o
);
   localparam int NSIDE = 2;

   generate
      if (AW < 3) begin : g_bad_aw
         $error("xwdma_chan: AW must be at least 3");
      end
      if (CW < 1) begin : g_bad_cw
         $error("xwdma_chan: CW must be at least 1");
      end
   endgenerate

   phase_t            phase;
   logic [CW-1:0]     remain;
   logic [CW-1:0]     half_mark;
   logic [1:0]        src_sz_q, dst_sz_q;
   logic              src_inc_q, dst_inc_q;
   logic [DATA_W-1:0] hold_q;

   logic start_ok, rd_done, wr_done, last_wr;
   logic [NUM_EV-1:0] ev_set;

   assign start_ok = (phase == ST_IDLE) && start_i && (items_i != '0);
   assign rd_done  = (phase == ST_RD) && bus_ack_i && !bus_err_i;
   assign wr_done  = (phase == ST_WR) && bus_ack_i && !bus_err_i;
   assign last_wr  = wr_done && (remain == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= ST_IDLE;
         remain    <= '0;
         half_mark <= '0;
         src_sz_q  <= 2'd0;
         dst_sz_q  <= 2'd0;
         src_inc_q <= 1'b0;
         dst_inc_q <= 1'b0;
         hold_q    <= '0;
      end else begin
         case (phase)
            ST_IDLE: if (start_ok) begin
               phase     <= ST_RD;
               remain    <= items_i;
               half_mark <= items_i >> 1;
               src_sz_q  <= src_sz_i;
               dst_sz_q  <= dst_sz_i;
               src_inc_q <= src_inc_i;
               dst_inc_q <= dst_inc_i;
            end
            ST_RD: if (bus_err_i) begin
               phase <= ST_IDLE;
            end else if (bus_ack_i) begin
               hold_q <= bus_rdata_i;
               phase  <= ST_WR;
            end
            ST_WR: if (bus_err_i) begin
               phase <= ST_IDLE;
            end else if (bus_ack_i) begin
               remain <= remain - CW'(1);
               phase  <= (remain == CW'(1)) ? ST_IDLE : ST_RD;
            end
            default: phase <= ST_IDLE;
         endcase
      end
   end

   // Address pointers, one per side
   logic [AW-1:0] ptr_base [NSIDE];
   logic          ptr_adv  [NSIDE];
   logic          ptr_inc  [NSIDE];
   logic [1:0]    ptr_sz   [NSIDE];
   logic [AW-1:0] ptr_addr [NSIDE];

   assign ptr_base[0] = src_base_i;
   assign ptr_base[1] = dst_base_i;
   assign ptr_adv[0]  = rd_done;
   assign ptr_adv[1]  = wr_done;
   assign ptr_inc[0]  = src_inc_q;
   assign ptr_inc[1]  = dst_inc_q;
   assign ptr_sz[0]   = src_sz_q;
   assign ptr_sz[1]   = dst_sz_q;

   generate
      for (genvar s = 0; s < NSIDE; s++) begin : g_side
         xwdma_ptr #(.AW(AW)) u_ptr (
            .clk  (clk),
            .rst_n(rst_n),
            .load (start_ok),
            .base (ptr_base[s]),
            .adv  (ptr_adv[s]),
            .inc  (ptr_inc[s]),
            .sz   (ptr_sz[s]),
            .addr (ptr_addr[s])
         );
      end
   endgenerate

   xwdma_fit #(.ZERO_PAD(1'b1)) u_fit (
      .din   (hold_q),
      .src_sz(src_sz_q),
      .dst_sz(dst_sz_q),
      .dout  (bus_wdata_o)
   );

   assign ev_set[EV_HALF] = wr_done && ((remain - CW'(1)) == half_mark);
   assign ev_set[EV_DONE] = last_wr;
   assign ev_set[EV_ERR]  = bus_req_o && bus_err_i;

   xwdma_evt #(.NEV(NUM_EV)) u_evt (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (ev_set),
      .clr  (ev_clr_i),
      .ie   (ev_ie_i),
      .flag (ev_flag_o),
      .irq  (irq_o)
   );

   assign busy_o     = (phase != ST_IDLE);
   assign bus_req_o  = busy_o;
   assign bus_we_o   = (phase == ST_WR);
   assign bus_addr_o = bus_we_o ? ptr_addr[1] : ptr_addr[0];
   assign bus_size_o = bus_we_o ? dst_sz_q : src_sz_q;

   // R4
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_we_o && bus_ack_i && !bus_err_i) |=> (bus_req_o && bus_we_o));
   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && !bus_ack_i && !bus_err_i) |=>
         (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));
   // R9
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_err_i) |=> !bus_req_o);
   // R3
   byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_o && bus_we_o && bus_size_o == 2'd0) |-> (bus_wdata_o[DATA_W-1:8] == '0));
endmodule

// File: tb/xwdma_chan_bench.sv
module xwdma_chan_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [AW-1:0] src_base_i = '0, dst_base_i = '0;
   logic [CW-1:0] items_i = '0;
   logic [1:0]    src_sz_i = 2'd0, dst_sz_i = 2'd0;
   logic          src_inc_i = 1'b0, dst_inc_i = 1'b0;
   logic [2:0]    ev_clr_i = 3'b0, ev_ie_i = 3'b0;
   logic          bus_req_o, bus_we_o;
   logic [AW-1:0] bus_addr_o;
   logic [1:0]    bus_size_o;
   logic [31:0]   bus_wdata_o;
   logic [31:0]   bus_rdata_i = '0;
   logic          bus_ack_i = 1'b0, bus_err_i = 1'b0;
   logic          busy_o;
   logic [2:0]    ev_flag_o;
   logic          irq_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   xwdma_chan #(.AW(AW), .CW(CW)) u_xwdma_chan (.*);

   int n_chk = 0;
   int n_bad = 0;
   int acc_idx = 0;
   int err_idx = -1;
   int slow = 0;
   int waited = 0;
   int n_log = 0;
   int req_seen = 0;
   logic [AW-1:0] log_addr [32];
   logic [31:0]   log_data [32];
   logic          log_we   [32];
   logic [1:0]    log_size [32];

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {a[15:0] ^ 16'h5AC3, ~a[15:0]};
   endfunction

   function automatic logic [31:0] msk(input logic [1:0] sz);
      return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] stp(input logic [1:0] sz);
      return (sz == 2'd0) ? 32'd1 : (sz == 2'd1) ? 32'd2 : 32'd4;
   endfunction

   // bus responder, decides the response for the coming edge
   initial begin
      forever begin
         @(negedge clk);
         bus_ack_i = 1'b0;
         bus_err_i = 1'b0;
         if (rst_n && bus_req_o) begin
            req_seen++;
            if (slow != 0 && waited == 0) begin
               waited = 1;
            end else begin
               waited = 0;
               if (acc_idx == err_idx) begin
                  bus_err_i = 1'b1;
               end else begin
                  bus_ack_i = 1'b1;
                  bus_rdata_i = pat(bus_addr_o);
                  if (n_log < 32) begin
                     log_addr[n_log] = bus_addr_o;
                     log_data[n_log] = bus_wdata_o;
                     log_we[n_log]   = bus_we_o;
                     log_size[n_log] = bus_size_o;
                     n_log++;
                  end
               end
               acc_idx++;
            end
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk);
      ev_clr_i = 3'b111;
      @(negedge clk);
      ev_clr_i = 3'b000;
      n_log = 0; acc_idx = 0; waited = 0; req_seen = 0;
   endtask

   task automatic launch(input logic [31:0] sb, input logic [31:0] db, input int n,
                         input logic [1:0] ss, input logic [1:0] ds,
                         input logic si, input logic di);
      src_base_i = sb; dst_base_i = db; items_i = CW'(n);
      src_sz_i = ss; dst_sz_i = ds; src_inc_i = si; dst_inc_i = di;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
   endtask

   task automatic check_items(input string req, input logic [31:0] sb, input logic [31:0] db,
                              input int n, input logic [1:0] ss, input logic [1:0] ds,
                              input logic si, input logic di);
      logic [31:0] sa, da;
      sa = sb; da = db;
      check("R6 access count", 32'(n_log), 32'(2*n));
      for (int i = 0; i < n && 2*i+1 < n_log; i++) begin
         check("R4 read direction", 32'(log_we[2*i]), 32'd0);
         check("R5 read address", log_addr[2*i], sa);
         check("R1 read size", 32'(log_size[2*i]), 32'(ss));
         check("R4 write direction", 32'(log_we[2*i+1]), 32'd1);
         check("R5 write address", log_addr[2*i+1], da);
         check("R1 write size", 32'(log_size[2*i+1]), 32'(ds));
         check("R2 R3 write data", log_data[2*i+1], pat(sa) & msk(ss) & msk(ds));
         if (si) sa = sa + stp(ss);
         if (di) da = da + stp(ds);
      end
   endtask

   task automatic t_reset();
      check("R6 reset busy", 32'(busy_o), 32'd0);
      check("R10 reset flags", 32'(ev_flag_o), 32'd0);
      check("R11 reset irq", 32'(irq_o), 32'd0);
      check("R4 reset req", 32'(bus_req_o), 32'd0);
   endtask

   // half-word to word, both increment: widening (R2)
   task automatic t_widen();
      clear_all();
      launch(32'h100, 32'h2000, 4, 2'd1, 2'd2, 1'b1, 1'b1);
      wait_idle();
      check_items("R2", 32'h100, 32'h2000, 4, 2'd1, 2'd2, 1'b1, 1'b1);
      check("R7 complete flag", 32'(ev_flag_o[1]), 32'd1);
      check("R8 half flag", 32'(ev_flag_o[0]), 32'd1);
      check("R9 no error flag", 32'(ev_flag_o[2]), 32'd0);
      ev_ie_i = 3'b010; #1;
      check("R11 irq enabled", 32'(irq_o), 32'd1);
      ev_ie_i = 3'b100; #1;
      check("R11 irq masked", 32'(irq_o), 32'd0);
      ev_ie_i = 3'b000;
   endtask

   // word to byte, destination fixed, with wait states: narrowing (R3)
   task automatic t_narrow();
      clear_all();
      slow = 1;
      launch(32'h340, 32'h8000, 3, 2'd0 + 2'd2, 2'd0, 1'b1, 1'b0);
      wait_idle();
      slow = 0;
      check_items("R3", 32'h340, 32'h8000, 3, 2'd2, 2'd0, 1'b1, 1'b0);
      check("R7 complete flag odd", 32'(ev_flag_o[1]), 32'd1);
   endtask

   // half flag timing: N=5, half after 3 items (2 remain)
   task automatic t_half();
      clear_all();
      slow = 1;
      launch(32'h500, 32'h600, 5, 2'd0, 2'd1, 1'b1, 1'b1);
      for (int i = 0; i < 400 && n_log < 5; i++) @(negedge clk);
      @(negedge clk);
      check("R8 half not after 2 items", 32'(ev_flag_o[0]), 32'd0);
      for (int i = 0; i < 400 && n_log < 6; i++) @(negedge clk);
      @(negedge clk);
      check("R8 half after 3 items", 32'(ev_flag_o[0]), 32'd1);
      check("R7 not complete yet", 32'(ev_flag_o[1]), 32'd0);
      wait_idle();
      slow = 0;
      check_items("R1", 32'h500, 32'h600, 5, 2'd0, 2'd1, 1'b1, 1'b1);
   endtask

   // word to half, source fixed, code 3 acts as word
   task automatic t_code3();
      clear_all();
      launch(32'h700, 32'h900, 2, 2'd3, 2'd1, 1'b0, 1'b1);
      wait_idle();
      check_items("R1", 32'h700, 32'h900, 2, 2'd3, 2'd1, 1'b0, 1'b1);
   endtask

   // error on the second item's read
   task automatic t_error();
      clear_all();
      err_idx = 2;
      launch(32'hA00, 32'hB00, 4, 2'd2, 2'd2, 1'b1, 1'b1);
      wait_idle();
      check("R9 completed accesses", 32'(n_log), 32'd2);
      check("R9 error flag", 32'(ev_flag_o[2]), 32'd1);
      check("R9 no complete", 32'(ev_flag_o[1]), 32'd0);
      req_seen = 0;
      repeat (6) @(negedge clk);
      check("R9 quiet after error", 32'(req_seen), 32'd0);
      ev_ie_i = 3'b100; #1;
      check("R11 error irq", 32'(irq_o), 32'd1);
      ev_ie_i = 3'b000;
      err_idx = -1;
      clear_all();
      launch(32'hA00, 32'hB00, 1, 2'd2, 2'd2, 1'b1, 1'b1);
      wait_idle();
      check("R9 restart after error", 32'(ev_flag_o), 32'b011);
   endtask

   // set and clear in the same cycle: set wins, later clear works
   task automatic t_clear();
      clear_all();
      launch(32'hC00, 32'hD00, 1, 2'd0, 2'd0, 1'b0, 1'b0);
      for (int i = 0; i < 100 && !(bus_req_o && bus_we_o); i++) @(negedge clk);
      ev_clr_i = 3'b010;
      @(negedge clk);
      ev_clr_i = 3'b000;
      check("R10 set wins over clear", 32'(ev_flag_o[1]), 32'd1);
      @(negedge clk);
      check("R10 flag sticky", 32'(ev_flag_o[1]), 32'd1);
      ev_clr_i = 3'b010;
      @(negedge clk);
      ev_clr_i = 3'b000;
      check("R10 clear resets flag", 32'(ev_flag_o[1]), 32'd0);
      check("R10 clear leaves half", 32'(ev_flag_o[0]), 32'd1);
   endtask

   // zero count
   task automatic t_zero();
      clear_all();
      launch(32'hE00, 32'hF00, 0, 2'd2, 2'd2, 1'b1, 1'b1);
      check("R6 zero count busy", 32'(busy_o), 32'd0);
      repeat (4) @(negedge clk);
      check("R6 zero count no access", 32'(req_seen), 32'd0);
      check("R6 zero count no flags", 32'(ev_flag_o), 32'd0);
   endtask

   // start while busy is ignored
   task automatic t_restart_busy();
      clear_all();
      slow = 1;
      launch(32'h1100, 32'h1200, 2, 2'd1, 2'd1, 1'b1, 1'b1);
      @(negedge clk);
      launch(32'h3300, 32'h4400, 5, 2'd0, 2'd0, 1'b0, 1'b0);
      wait_idle();
      slow = 0;
      check_items("R12", 32'h1100, 32'h1200, 2, 2'd1, 2'd1, 1'b1, 1'b1);
      repeat (3) @(negedge clk);
      check("R12 no extra run", 32'(busy_o), 32'd0);
   endtask

   task automatic report();
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_widen();
      t_narrow();
      t_half();
      t_code3();
      t_error();
      t_clear();
      t_zero();
      t_restart_busy();
      report();
   end
endmodule